// File: doc/BRIEF.md
# Issue Queue Wakeup and Select

This block holds decoded operations that wait for their source operands before they go to execution. Each slot keeps a destination tag, two source tags with a ready flag each, a speculation mask that names the unresolved branches the operation depends on, and a relative age. Functional units that finish an operation announce its destination tag on one of several broadcast buses. Every slot compares every announced tag against both of its sources in parallel and marks the matching sources ready.

In the same cycle, the selector looks at all slots whose sources are ready (either already flagged or woken by a broadcast this cycle). It hands them to the issue ports that are free, oldest first. An issued slot is released at the next clock edge. Because wakeup and selection share one cycle, a consumer can leave the queue in the very cycle its producer's tag is announced. When a branch resolves as mispredicted, the slots that depend on it are dropped. A dispatch port accepts one operation per cycle while a free slot exists.

Top module: `iq_wakeup_select`

## Requirements
- R1: After reset no slot is occupied: all `iss_valid` bits are 0 and `disp_ready` is 1.
- R2: A slot is issued only when both of its sources are ready and it is given an issue port whose `fu_avail` bit is 1. A slot with an unready source, or with no available port, stays in the queue.
- R3: A tag on any valid broadcast bus marks every matching source ready. A slot whose last missing source is announced this way issues in that same cycle.
- R4: A dispatched source counts as ready when its `disp_srcN_rdy` bit is 1, or when its tag equals a tag on a valid broadcast bus in the dispatch cycle.
- R5: Ready slots are ranked by dispatch order. The oldest goes to the lowest-numbered port whose `fu_avail` bit is 1, the next oldest to the next such port, and so on.
- R6: At most `ISSUE_W` slots issue per cycle, each on a distinct port. An issued slot is freed at the next edge and never issues again.
- R7: `disp_ready` is 0 while all `DEPTH` slots are occupied. A dispatch offered then is discarded and never issues.
- R8: When `squash_valid` is 1, every slot whose mask shares a set bit with `squash_mask` is dropped and does not issue in that cycle. A dispatch in that cycle whose mask shares a bit with `squash_mask` is discarded.
- R9: Age order holds however long a slot waits, no matter how many younger operations pass through the queue meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free slot exists |
| disp_dst | input | TAG_W | Destination tag of the dispatched operation |
| disp_src0_tag | input | TAG_W | First source tag |
| disp_src0_rdy | input | 1 | First source already available (or unused) |
| disp_src1_tag | input | TAG_W | Second source tag |
| disp_src1_rdy | input | 1 | Second source already available (or unused) |
| disp_brmask | input | MASK_W | Branches the dispatched operation depends on |
| bc_valid | input | NBCAST | One valid bit per broadcast bus |
| bc_tags | input | NBCAST*TAG_W | Broadcast tags, bus k in bits [k*TAG_W +: TAG_W] |
| squash_valid | input | 1 | Branch misprediction announcement |
| squash_mask | input | MASK_W | Mispredicted branch bits |
| fu_avail | input | ISSUE_W | Issue port k may accept an operation this cycle |
| iss_valid | output | ISSUE_W | Issue port k carries an operation |
| iss_dst | output | ISSUE_W*TAG_W | Destination tag per issue port |
| iss_src0_tag | output | ISSUE_W*TAG_W | First source tag per issue port |
| iss_src1_tag | output | ISSUE_W*TAG_W | Second source tag per issue port |

## Verification
The bench checks back-to-back issue. A design that registered the wakeup would hold the consumer for one extra cycle after its producer's tag appears. A dispatch that coincides with the broadcast of its source must still issue next cycle. A queue that ignored that broadcast would strand the slot forever. Age ranking is checked with a gap in the available ports and after a long stream of younger operations passes an old waiting slot, where a wrapping counter or a slot-index priority would pick the wrong operation. It also checks that a full queue discards the extra dispatch, and that a squash removes the dependent slot in the same cycle instead of letting it issue once more.

// File: rtl/iq_ws_pkg.sv
`timescale 1ns/1ps
package iq_ws_pkg;
   localparam int unsigned IQ_DEPTH_DEF  = 8;
   localparam int unsigned IQ_TAG_DEF    = 6;
   localparam int unsigned IQ_BCAST_DEF  = 3;
   localparam int unsigned IQ_ISSUE_DEF  = 2;
   localparam int unsigned IQ_MASK_DEF   = 4;
   localparam int unsigned IQ_SRC_PER_OP = 2;
endpackage

// File: rtl/iq_ws_tag_match.sv
`timescale 1ns/1ps
// Parallel comparison of M stored tags against all broadcast buses.
module iq_ws_tag_match #(
   parameter int unsigned M      = 2,
   parameter int unsigned NBCAST = 3,
   parameter int unsigned TAG_W  = 6
) (
   input  logic [M*TAG_W-1:0]      tags,
   input  logic [NBCAST-1:0]       bc_valid,
   input  logic [NBCAST*TAG_W-1:0] bc_tags,
   output logic [M-1:0]            hit
);
   for (genvar m = 0; m < M; m++) begin : g_cmp
      always_comb begin
         hit[m] = 1'b0;
         for (int b = 0; b < NBCAST; b++)
            if (bc_valid[b] && bc_tags[b*TAG_W +: TAG_W] == tags[m*TAG_W +: TAG_W])
               hit[m] = 1'b1;
      end
   end
endmodule

// File: rtl/iq_ws_older_count.sv
`timescale 1ns/1ps
// For each entry, counts flagged entries with a smaller age value.
module iq_ws_older_count #(
   parameter int unsigned N  = 8,
   parameter int unsigned AW = 3,
   parameter int unsigned CW = 4
) (
   input  logic [N-1:0]    flag,
   input  logic [N*AW-1:0] age,
   output logic [N*CW-1:0] cnt
);
   for (genvar i = 0; i < N; i++) begin : g_row
      logic [CW-1:0] acc;
      always_comb begin
         acc = '0;
         for (int j = 0; j < N; j++)
            if (j != i && flag[j] && age[j*AW +: AW] < age[i*AW +: AW])
               acc = acc + 1'b1;
      end
      assign cnt[i*CW +: CW] = acc;
   end
endmodule

// File: rtl/iq_ws_slot_map.sv
`timescale 1ns/1ps
// Maps the k-th oldest candidate onto the k-th available issue port.
module iq_ws_slot_map #(
   parameter int unsigned N  = 8,
   parameter int unsigned W  = 2,
   parameter int unsigned CW = 4,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]    cand,
   input  logic [N*CW-1:0] rank,
   input  logic [W-1:0]    fu_avail,
   output logic [W-1:0]    slot_vld,
   output logic [W*IW-1:0] slot_idx,
   output logic [N-1:0]    grant
);
   logic [N-1:0] hit [W];

   for (genvar s = 0; s < W; s++) begin : g_slot
      logic [CW-1:0] order;
      always_comb begin
         order = '0;
         for (int t = 0; t < s; t++)
            order = order + CW'(fu_avail[t]);
      end
      always_comb begin
         slot_vld[s]            = 1'b0;
         slot_idx[s*IW +: IW]   = '0;
         for (int i = 0; i < N; i++) begin
            hit[s][i] = fu_avail[s] && cand[i] && rank[i*CW +: CW] == order;
            if (hit[s][i]) begin
               slot_vld[s]          = 1'b1;
               slot_idx[s*IW +: IW] = IW'(i);
            end
         end
      end
   end

   always_comb begin
      grant = '0;
      for (int s = 0; s < W; s++)
         grant = grant | hit[s];
   end
endmodule

// File: rtl/iq_wakeup_select.sv
`timescale 1ns/1ps
module iq_wakeup_select
   import iq_ws_pkg::*;
#(
   parameter int unsigned DEPTH     = IQ_DEPTH_DEF,
   parameter int unsigned TAG_W     = IQ_TAG_DEF,
   parameter int unsigned NBCAST    = IQ_BCAST_DEF,
   parameter int unsigned ISSUE_W   = IQ_ISSUE_DEF,
   parameter int unsigned MASK_W    = IQ_MASK_DEF,
   parameter bit          DISP_WAKE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      disp_valid,
   output logic                      disp_ready,
   input  logic [TAG_W-1:0]          disp_dst,
   input  logic [TAG_W-1:0]          disp_src0_tag,
   input  logic                      disp_src0_rdy,
   input  logic [TAG_W-1:0]          disp_src1_tag,
   input  logic                      disp_src1_rdy,
   input  logic [MASK_W-1:0]         disp_brmask,
   input  logic [NBCAST-1:0]         bc_valid,
   input  logic [NBCAST*TAG_W-1:0]   bc_tags,
   input  logic                      squash_valid,
   input  logic [MASK_W-1:0]         squash_mask,
   input  logic [ISSUE_W-1:0]        fu_avail,
   output logic [ISSUE_W-1:0]        iss_valid,
   output logic [ISSUE_W*TAG_W-1:0]  iss_dst,
   output logic [ISSUE_W*TAG_W-1:0]  iss_src0_tag,
   output logic [ISSUE_W*TAG_W-1:0]  iss_src1_tag
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam int unsigned IW = AW;

   if (DEPTH < 2 || ISSUE_W < 1 || ISSUE_W > DEPTH || NBCAST < 1 ||
       TAG_W < 1 || MASK_W < 1 || IQ_SRC_PER_OP != 2) begin : g_bad_cfg
      $error("iq_wakeup_select: unsupported parameter set");
   end

   // slot storage
   logic [DEPTH-1:0]        e_vld, e_rdy0, e_rdy1;
   logic [DEPTH*TAG_W-1:0]  e_dst, e_s0, e_s1;
   logic [DEPTH*MASK_W-1:0] e_mask;
   logic [DEPTH*AW-1:0]     e_age;

   // wakeup
   logic [2*DEPTH-1:0] e_hit;
   logic [1:0]         d_hit;
   logic [DEPTH-1:0]   ok0, ok1, sq_hit, cand, grant, removed, keep;
   logic [DEPTH*CW-1:0] rank, drop;
   logic [ISSUE_W-1:0]     slot_vld;
   logic [ISSUE_W*IW-1:0]  slot_idx;
   logic [CW-1:0]      survivors;
   logic [IW-1:0]      alloc_idx;
   logic               disp_take, disp_sq;

   iq_ws_tag_match #(.M(2*DEPTH), .NBCAST(NBCAST), .TAG_W(TAG_W)) u_wake (
      .tags({e_s1, e_s0}), .bc_valid(bc_valid), .bc_tags(bc_tags), .hit(e_hit));

   if (DISP_WAKE) begin : g_disp_wake
      iq_ws_tag_match #(.M(2), .NBCAST(NBCAST), .TAG_W(TAG_W)) u_dwake (
         .tags({disp_src1_tag, disp_src0_tag}), .bc_valid(bc_valid),
         .bc_tags(bc_tags), .hit(d_hit));
   end else begin : g_no_disp_wake
      assign d_hit = '0;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign ok0[i]    = e_rdy0[i] | e_hit[i];
      assign ok1[i]    = e_rdy1[i] | e_hit[DEPTH+i];
      assign sq_hit[i] = squash_valid && |(e_mask[i*MASK_W +: MASK_W] & squash_mask);
   end

   assign cand = e_vld & ok0 & ok1 & ~sq_hit;

   // select: age rank of every candidate, then port mapping
   iq_ws_older_count #(.N(DEPTH), .AW(AW), .CW(CW)) u_rank (
      .flag(cand), .age(e_age), .cnt(rank));

   iq_ws_slot_map #(.N(DEPTH), .W(ISSUE_W), .CW(CW), .IW(IW)) u_map (
      .cand(cand), .rank(rank), .fu_avail(fu_avail),
      .slot_vld(slot_vld), .slot_idx(slot_idx), .grant(grant));

   // age compaction: each survivor moves down by the removed older slots
   assign removed = e_vld & (grant | sq_hit);
   assign keep    = e_vld & ~removed;

   iq_ws_older_count #(.N(DEPTH), .AW(AW), .CW(CW)) u_drop (
      .flag(removed), .age(e_age), .cnt(drop));

   always_comb begin
      survivors = '0;
      for (int i = 0; i < DEPTH; i++)
         survivors = survivors + CW'(keep[i]);
   end

   always_comb begin
      alloc_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (!e_vld[i]) alloc_idx = IW'(i);
   end

   assign disp_ready = ~&e_vld;
   assign disp_sq    = squash_valid && |(disp_brmask & squash_mask);
   assign disp_take  = disp_valid && disp_ready && !disp_sq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_vld  <= '0;
         e_rdy0 <= '0;
         e_rdy1 <= '0;
         e_dst  <= '0;
         e_s0   <= '0;
         e_s1   <= '0;
         e_mask <= '0;
         e_age  <= '0;
      end else begin
         e_vld <= keep;
         for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
               e_rdy0[i] <= ok0[i];
               e_rdy1[i] <= ok1[i];
               e_age[i*AW +: AW] <= e_age[i*AW +: AW] - drop[i*CW +: AW];
            end
         end
         if (disp_take) begin
            e_vld[alloc_idx]                  <= 1'b1;
            e_rdy0[alloc_idx]                 <= disp_src0_rdy | d_hit[0];
            e_rdy1[alloc_idx]                 <= disp_src1_rdy | d_hit[1];
            e_dst[alloc_idx*TAG_W +: TAG_W]   <= disp_dst;
            e_s0[alloc_idx*TAG_W +: TAG_W]    <= disp_src0_tag;
            e_s1[alloc_idx*TAG_W +: TAG_W]    <= disp_src1_tag;
            e_mask[alloc_idx*MASK_W +: MASK_W] <= disp_brmask;
            e_age[alloc_idx*AW +: AW]         <= survivors[AW-1:0];
         end
      end
   end

   assign iss_valid = slot_vld;
   for (genvar s = 0; s < ISSUE_W; s++) begin : g_out
      logic [IW-1:0] idx;
      assign idx = slot_idx[s*IW +: IW];
      assign iss_dst[s*TAG_W +: TAG_W]      = e_dst[idx*TAG_W +: TAG_W];
      assign iss_src0_tag[s*TAG_W +: TAG_W] = e_s0[idx*TAG_W +: TAG_W];
      assign iss_src1_tag[s*TAG_W +: TAG_W] = e_s1[idx*TAG_W +: TAG_W];
   end
endmodule

// File: rtl/iq_ws_checker.sv
`timescale 1ns/1ps
module iq_ws_checker #(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned ISSUE_W = 2,
   parameter int unsigned MASK_W  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ISSUE_W-1:0]      fu_avail,
   input logic [ISSUE_W-1:0]      iss_valid,
   input logic                    disp_ready,
   input logic                    squash_valid,
   input logic [MASK_W-1:0]       squash_mask,
   input logic [DEPTH-1:0]        e_vld,
   input logic [DEPTH-1:0]        grant,
   input logic [DEPTH*MASK_W-1:0] e_mask
);
   for (genvar s = 0; s < ISSUE_W; s++) begin : g_port
      assert_port_needs_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[s] |-> fu_avail[s]);
   end

   assert_ports_match_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(iss_valid) == $countones(grant));

   assert_full_blocks_dispatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (&e_vld) |-> !disp_ready);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assert_issued_slot_freed_R6: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |=> !e_vld[i]);

      assert_grant_only_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |-> e_vld[i]);

      assert_squash_no_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (squash_valid && e_vld[i] && |(e_mask[i*MASK_W +: MASK_W] & squash_mask))
            |-> !grant[i]);

      assert_squash_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (squash_valid && e_vld[i] && |(e_mask[i*MASK_W +: MASK_W] & squash_mask))
            |=> !e_vld[i]);
   end
endmodule

bind iq_wakeup_select iq_ws_checker #(
   .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .MASK_W(MASK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fu_avail(fu_avail), .iss_valid(iss_valid),
   .disp_ready(disp_ready), .squash_valid(squash_valid), .squash_mask(squash_mask),
   .e_vld(e_vld), .grant(grant), .e_mask(e_mask)
);

// File: tb/iq_wakeup_select_test.sv
`timescale 1ns/1ps
module iq_wakeup_select_test;
   localparam int DEPTH = 8, TAG_W = 6, NBC = 3, IW = 2, MW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic disp_valid, disp_ready, disp_src0_rdy, disp_src1_rdy, squash_valid;
   logic [TAG_W-1:0] disp_dst, disp_src0_tag, disp_src1_tag;
   logic [MW-1:0] disp_brmask, squash_mask;
   logic [NBC-1:0] bc_valid;
   logic [NBC*TAG_W-1:0] bc_tags;
   logic [IW-1:0] fu_avail, iss_valid;
   logic [IW*TAG_W-1:0] iss_dst, iss_src0_tag, iss_src1_tag;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   iq_wakeup_select #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NBCAST(NBC), .ISSUE_W(IW), .MASK_W(MW)) uut (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
      .disp_dst(disp_dst), .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
      .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy), .disp_brmask(disp_brmask),
      .bc_valid(bc_valid), .bc_tags(bc_tags), .squash_valid(squash_valid),
      .squash_mask(squash_mask), .fu_avail(fu_avail), .iss_valid(iss_valid),
      .iss_dst(iss_dst), .iss_src0_tag(iss_src0_tag), .iss_src1_tag(iss_src1_tag));

   task automatic idle_in();
      disp_valid = 0; disp_dst = '0; disp_src0_tag = '0; disp_src1_tag = '0;
      disp_src0_rdy = 0; disp_src1_rdy = 0; disp_brmask = '0;
      bc_valid = '0; bc_tags = '0; squash_valid = 0; squash_mask = '0;
   endtask

   // begin a new cycle: inputs change just after the falling edge
   task automatic step();
      @(negedge clk);
      idle_in();
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic put_disp(input int dst, input int s0, input bit r0,
                           input int s1, input bit r1, input int mask);
      disp_valid = 1; disp_dst = TAG_W'(dst);
      disp_src0_tag = TAG_W'(s0); disp_src0_rdy = r0;
      disp_src1_tag = TAG_W'(s1); disp_src1_rdy = r1;
      disp_brmask = MW'(mask);
   endtask

   task automatic put_bc(input int bus, input int tag);
      bc_valid[bus] = 1'b1;
      bc_tags[bus*TAG_W +: TAG_W] = TAG_W'(tag);
   endtask

   task automatic chk_port(input int s, input bit ev, input int edst, input string rq);
      logic [TAG_W-1:0] got;
      got = iss_dst[s*TAG_W +: TAG_W];
      n_chk++;
      if (iss_valid[s] !== ev || (ev && got !== TAG_W'(edst))) begin
         n_bad++;
         $display("FAIL %s port%0d: got valid=%0b dst=%0d, expected valid=%0b dst=%0d",
                  rq, s, iss_valid[s], got, ev, edst);
      end
   endtask

   task automatic chk_idle(input string rq);
      chk_port(0, 0, 0, rq);
      chk_port(1, 0, 0, rq);
   endtask

   task automatic chk_val(input string rq, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d, expected %0d", rq, got, exp);
      end
   endtask

   // R1
   task automatic t_reset();
      step(); settle();
      chk_idle("R1 no issue after reset");
      chk_val("R1 dispatch ready after reset", int'(disp_ready), 1);
   endtask

   // R2, R3, R6: producer then dependent consumer back to back
   task automatic t_back_to_back();
      fu_avail = 2'b11;
      step(); put_disp(5, 1, 1, 2, 1, 0); settle();
      chk_idle("R2 empty queue");
      step(); put_disp(6, 5, 0, 3, 1, 0); settle();
      chk_port(0, 1, 5, "R2 ready producer issues");
      chk_port(1, 0, 0, "R6 single issue");
      step(); settle();
      chk_idle("R2 unready consumer waits");
      step(); put_bc(2, 5); settle();
      chk_port(0, 1, 6, "R3 same-cycle wakeup issue");
      step(); settle();
      chk_idle("R6 issued slot freed");
   endtask

   // R4: dispatch concurrent with broadcast
   task automatic t_disp_capture();
      fu_avail = 2'b11;
      step(); put_disp(9, 7, 0, 8, 0, 0); put_bc(0, 7); put_bc(1, 8); settle();
      chk_idle("R4 dispatch cycle no issue");
      step(); put_disp(12, 14, 0, 15, 1, 0); put_bc(0, 13); settle();
      chk_port(0, 1, 9, "R4 captured wakeup");
      chk_val("R4 src0 tag out", int'(iss_src0_tag[TAG_W-1:0]), 7);
      chk_val("R4 src1 tag out", int'(iss_src1_tag[TAG_W-1:0]), 8);
      step(); settle();
      chk_idle("R4 mismatched tag not captured");
      step(); put_bc(1, 14); settle();
      chk_port(0, 1, 12, "R3 later wakeup");
      step(); settle();
   endtask

   // R5, R2: age order onto available ports
   task automatic t_age_order();
      fu_avail = 2'b00;
      step(); put_disp(1, 0, 1, 0, 1, 0); settle(); chk_idle("R2 no unit");
      step(); put_disp(2, 0, 1, 0, 1, 0); settle(); chk_idle("R2 no unit");
      step(); put_disp(3, 0, 1, 0, 1, 0); settle(); chk_idle("R2 no unit");
      step(); fu_avail = 2'b11; settle();
      chk_port(0, 1, 1, "R5 oldest on port0");
      chk_port(1, 1, 2, "R5 second on port1");
      step(); settle();
      chk_port(0, 1, 3, "R5 remaining");
      chk_port(1, 0, 0, "R6 nothing left");
      step(); fu_avail = 2'b00; put_disp(4, 0, 1, 0, 1, 0); settle();
      step(); put_disp(10, 0, 1, 0, 1, 0); settle();
      step(); fu_avail = 2'b10; settle();
      chk_port(0, 0, 0, "R2 port0 unavailable");
      chk_port(1, 1, 4, "R5 oldest to first free port");
      step(); settle();
      chk_port(1, 1, 10, "R5 next oldest");
      step(); fu_avail = 2'b00; settle();
   endtask

   // R9: old slot waits while many younger ones stream through
   task automatic t_long_wait();
      fu_avail = 2'b01;
      step(); put_disp(20, 30, 0, 0, 1, 0); settle();
      for (int k = 0; k < 20; k++) begin
         step(); put_disp(33, 0, 1, 0, 1, 0); settle();
         if (k > 0) chk_port(0, 1, 33, "R9 stream passes");
      end
      step(); fu_avail = 2'b00; put_disp(21, 0, 1, 0, 1, 0); settle();
      chk_port(0, 0, 0, "R2 port off");
      step(); fu_avail = 2'b01; settle();
      chk_port(0, 1, 33, "R9 last streamed");
      step(); fu_avail = 2'b01; put_bc(1, 30); settle();
      chk_port(0, 1, 20, "R9 long-waiting slot is oldest");
      step(); settle();
      chk_port(0, 1, 21, "R9 younger after");
      step(); fu_avail = 2'b00; settle();
   endtask

   // R7: full queue discards dispatch
   task automatic t_full();
      fu_avail = 2'b00;
      for (int k = 0; k < DEPTH; k++) begin
         step(); put_disp(40 + k, 50, 0, 0, 1, 0); settle();
      end
      step(); settle();
      chk_val("R7 full deasserts ready", int'(disp_ready), 0);
      put_disp(60, 0, 1, 0, 1, 0);
      step(); fu_avail = 2'b11; put_bc(0, 50); settle();
      chk_port(0, 1, 40, "R7 oldest after fill");
      chk_port(1, 1, 41, "R7 second after fill");
      for (int k = 1; k < DEPTH / 2; k++) begin
         step(); settle();
         chk_port(0, 1, 40 + 2 * k, "R7 drain");
         chk_port(1, 1, 41 + 2 * k, "R7 drain");
      end
      step(); settle();
      chk_idle("R7 discarded dispatch never issues");
      chk_val("R7 ready after drain", int'(disp_ready), 1);
      fu_avail = 2'b00;
   endtask

   // R8: squash removes dependent slots and dispatch
   task automatic t_squash();
      fu_avail = 2'b00;
      step(); put_disp(11, 0, 1, 0, 1, 1); settle();
      step(); put_disp(12, 0, 1, 0, 1, 2); settle();
      step(); put_disp(13, 0, 1, 0, 1, 0); settle();
      step(); fu_avail = 2'b11; squash_valid = 1; squash_mask = 4'b0001; settle();
      chk_port(0, 1, 12, "R8 squashed slot skipped");
      chk_port(1, 1, 13, "R8 unrelated slot issues");
      step(); settle();
      chk_idle("R8 squashed slot gone");
      step(); fu_avail = 2'b00; put_disp(14, 0, 1, 0, 1, 4);
      squash_valid = 1; squash_mask = 4'b0100; settle();
      step(); fu_avail = 2'b11; settle();
      chk_idle("R8 dispatch during squash discarded");
      step(); fu_avail = 2'b00; settle();
   endtask

   initial begin
      idle_in();
      fu_avail = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_back_to_back();
      t_disp_capture();
      t_age_order();
      t_long_wait();
      t_full();
      t_squash();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule